// File: doc/BRIEF.md
# JTAG Debug Register-Access Unit

This block lets a debug host read and write registers on an on-chip register bus through a standard four-wire test port. It contains a test access port state machine and a 4-bit instruction register that selects one of three data paths:

- a chain-select register, which chooses the target scan chain;
- a register-access register, which carries address, direction, data and a checksum;
- a one-bit bypass path.

Both the chain-select and register-access frames are protected by an 8-bit CRC. A frame with a bad checksum or a wrong length has no effect on the chain selection or on the bus. It raises a sticky error flag instead.

When a valid register-access frame reaches Update-DR while the register chain is selected, the unit starts one access on the system-clock register bus. The request crosses from the test clock into the system clock through a toggle synchroniser. The completion, and any read data, return through a second toggle synchroniser.

The bus request side is a valid/ready channel. Once `bus_valid` rises, `bus_addr`, `bus_wr` and `bus_wdata` hold steady until the cycle in which `bus_ready` is high; that cycle is the whole transfer. For a read, `bus_rdata` is sampled in that same cycle. The bus may stall with `bus_ready` low for as long as it needs. While an access is outstanding, the unit drops any further access frame.

Read data is latched by the access that fetched it. It is shifted out during the data field of the next register-access scan. A host therefore repeats a read to see its value.

Top module: `jtag_regacc_top`

## Requirements
- R1: `trst_n` low, or five TCK cycles with TMS high, puts the test port into Test-Logic-Reset. That state selects the bypass instruction, clears the chain selection to 0 and clears `crc_err`. `tdo_oe` is low there.
- R2: The instruction register is 4 bits wide and is shifted LSB first.
  - Code 0x3 selects the chain-select path and 0x8 selects register access; every other code selects the 1-bit bypass path.
  - Capture-IR loads 4'b0101, which appears on TDO bit 0 first.
  - The bypass path captures 0, so its output is the input delayed by one bit.
- R3: A chain-select frame is a 4-bit chain id (LSB first) followed by an 8-bit CRC (LSB first). It updates the chain selection at Update-DR only if it is exactly 12 bits long and its CRC matches. Otherwise the previous selection is kept.
- R4: The CRC is CRC-8 with polynomial x^8+x^2+x+1, initial value 0, computed over every bit that precedes the CRC field in shift order.
  - Each bit b updates the value c as: feedback = c[7]^b, then c = (c<<1) ^ (feedback ? 0x07 : 0).
  - The i-th CRC bit shifted in must equal bit i of c.
  - A mismatch sets `crc_err`, which stays high until Test-Logic-Reset.
- R5: A register-access frame is 73 bits, in this order: address[31:0], a direction bit (1 = write, 0 = read), data[31:0], then CRC[7:0], each field LSB first. A valid frame starts exactly one bus access with that address and direction, and for a write that data.
- R6: Register-access frames are ignored unless the selected chain id is 4. An ignored frame starts no bus access and does not set `crc_err`.
- R7: Read data returned by the bus is latched and shifted out on TDO during bits 33..64 of the next register-access scan, bit 0 first. All other bits of that scan read 0, and the latch is 0 after `trst_n`.
- R8: With `bus_ready` high and the system clock at least four times the TCK rate, a write reaches the bus within 10 TCK cycles after the TAP returns to Run-Test/Idle.
- R9: `bus_valid` stays high with `bus_addr`, `bus_wr` and `bus_wdata` stable until a cycle with `bus_ready` high. In the cycle after that handshake, `bus_valid` is low.
- R10: TDO changes only on the falling edge of TCK. `tdo_oe` is high only while the port is in Shift-IR or Shift-DR.
- R11: A valid access frame that completes while a previous access has not been acknowledged is dropped, without starting a bus access.
- R12: A register-access frame whose length is not exactly 73 bits starts no access and sets `crc_err`, if chain 4 is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test reset, active low, asynchronous |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Test data in |
| tdo | output | 1 | Test data out, updated on TCK falling edge |
| tdo_oe | output | 1 | TDO output enable, high in shift states |
| crc_err | output | 1 | Sticky CRC/length error flag |
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | System reset, active low, asynchronous |
| bus_valid | output | 1 | Bus access request valid |
| bus_ready | input | 1 | Bus accepts and completes the access |
| bus_addr | output | 32 | Access address |
| bus_wr | output | 1 | 1 = write, 0 = read |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, sampled with the handshake |

## Verification
The bench builds the unit with its default parameters:

- a 32-bit address and data,
- register chain id 4,
- two-stage synchronisers.

TCK runs at a quarter of the system clock rate. At that ratio the 10-cycle write completion window and the read-data return before the next scan both fall within reach. Holding `bus_ready` low over two access frames brings the outstanding-access drop and the request hold rules within reach. The CRC-corrupted, wrong-length and wrong-chain frames exercise every rejection path.

// File: rtl/jrg_pkg.sv
package jrg_pkg;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
  } tap_st_e;

  localparam int IR_W = 4;
  localparam int CRC_W = 8;
  localparam logic [IR_W-1:0] OP_CHAIN   = 4'h3;
  localparam logic [IR_W-1:0] OP_ACCESS  = 4'h8;
  localparam logic [IR_W-1:0] OP_BYPASS  = 4'hF;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0101;

  // one serial step of CRC-8, polynomial x^8+x^2+x+1
  function automatic logic [CRC_W-1:0] crc8_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
  endfunction

endpackage

// File: rtl/jrg_tap.sv
module jrg_tap
  import jrg_pkg::*;
(
  input  logic    tck,
  input  logic    trst_n,
  input  logic    tms,
  output tap_st_e st
);

  tap_st_e nxt;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PA_DR;
      ST_PA_DR:  nxt = tms ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PA_IR;
      ST_PA_IR:  nxt = tms ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
      default:   nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) st <= ST_TLR;
    else         st <= nxt;
  end

  // R1: TMS held high keeps the port in Test-Logic-Reset
  p_tlr_hold_r1: assert property (@(posedge tck) disable iff (!trst_n)
    (st == ST_TLR && tms) |=> (st == ST_TLR));

  // R2: leaving Shift-IR with TMS high always goes through Exit1-IR
  p_ir_exit_r2: assert property (@(posedge tck) disable iff (!trst_n)
    (st == ST_SH_IR && tms) |=> (st == ST_EX1_IR));

endmodule

// File: rtl/jrg_scan.sv
module jrg_scan
  import jrg_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int CHAIN_W   = 4,
  parameter int REG_CHAIN = 4
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tdi,
  input  tap_st_e           st,
  input  logic [DATA_W-1:0] rd_latch,
  output logic              tdo,
  output logic              tdo_oe,
  output logic              err,
  output logic              launch,
  output logic [ADDR_W-1:0] f_addr,
  output logic              f_wr,
  output logic [DATA_W-1:0] f_wdata
);

  localparam int ACC_BODY = ADDR_W + 1 + DATA_W;
  localparam int ACC_LEN  = ACC_BODY + CRC_W;
  localparam int CH_LEN   = CHAIN_W + CRC_W;
  localparam int CNT_MAX  = ACC_LEN + 1;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] ACC_BODY_C = CNT_W'(ACC_BODY);
  localparam logic [CNT_W-1:0] ACC_LEN_C  = CNT_W'(ACC_LEN);
  localparam logic [CNT_W-1:0] CH_BODY_C  = CNT_W'(CHAIN_W);
  localparam logic [CNT_W-1:0] CH_LEN_C   = CNT_W'(CH_LEN);
  localparam logic [CNT_W-1:0] CNT_MAX_C  = CNT_W'(CNT_MAX);
  localparam logic [CHAIN_W-1:0] REG_CHAIN_C = CHAIN_W'(REG_CHAIN);

  logic [IR_W-1:0]    ir_sr, ir_q;
  logic [ACC_LEN-1:0] acc_sr;
  logic [CH_LEN-1:0]  ch_sr;
  logic               byp_q;
  logic [CHAIN_W-1:0] chain_q;
  logic [CRC_W-1:0]   crc_q;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   body_len;
  logic               acc_ok, ch_ok, dr_bit, reg_sel;

  assign body_len = (ir_q == OP_ACCESS) ? ACC_BODY_C : CH_BODY_C;
  assign acc_ok   = (cnt == ACC_LEN_C) && (acc_sr[ACC_LEN-1 -: CRC_W] == crc_q);
  assign ch_ok    = (cnt == CH_LEN_C)  && (ch_sr[CH_LEN-1 -: CRC_W] == crc_q);
  assign reg_sel  = (chain_q == REG_CHAIN_C);

  assign f_addr  = acc_sr[ADDR_W-1:0];
  assign f_wr    = acc_sr[ADDR_W];
  assign f_wdata = acc_sr[ACC_BODY-1 -: DATA_W];
  assign launch  = (st == ST_UPD_DR) && (ir_q == OP_ACCESS) && reg_sel && acc_ok;

  always_comb begin
    unique case (ir_q)
      OP_ACCESS: dr_bit = acc_sr[0];
      OP_CHAIN:  dr_bit = ch_sr[0];
      default:   dr_bit = byp_q;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sr   <= '0;
      ir_q    <= OP_BYPASS;
      acc_sr  <= '0;
      ch_sr   <= '0;
      byp_q   <= 1'b0;
      chain_q <= '0;
      crc_q   <= '0;
      cnt     <= '0;
      err     <= 1'b0;
    end else begin
      unique case (st)
        ST_TLR: begin
          ir_q    <= OP_BYPASS;
          chain_q <= '0;
          err     <= 1'b0;
        end
        ST_CAP_IR: ir_sr <= IR_CAPTURE;
        ST_SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        ST_UPD_IR: ir_q  <= ir_sr;
        ST_CAP_DR: begin
          cnt    <= '0;
          crc_q  <= '0;
          byp_q  <= 1'b0;
          ch_sr  <= '0;
          acc_sr <= {{CRC_W{1'b0}}, rd_latch, 1'b0, {ADDR_W{1'b0}}};
        end
        ST_SH_DR: begin
          if (cnt != CNT_MAX_C) cnt <= cnt + 1'b1;
          if (cnt < body_len)   crc_q <= crc8_step(crc_q, tdi);
          unique case (ir_q)
            OP_ACCESS: acc_sr <= {tdi, acc_sr[ACC_LEN-1:1]};
            OP_CHAIN:  ch_sr  <= {tdi, ch_sr[CH_LEN-1:1]};
            default:   byp_q  <= tdi;
          endcase
        end
        ST_UPD_DR: begin
          if (ir_q == OP_CHAIN) begin
            if (ch_ok) chain_q <= ch_sr[CHAIN_W-1:0];
            else       err     <= 1'b1;
          end
          if (ir_q == OP_ACCESS && reg_sel && !acc_ok) err <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // TDO launched on the falling edge so the host samples it on the rising edge
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (st == ST_SH_IR) || (st == ST_SH_DR);
      tdo    <= (st == ST_SH_IR) ? ir_sr[0] : (st == ST_SH_DR) ? dr_bit : 1'b0;
    end
  end

  // R10: output enable only in the shift states
  p_oe_in_shift_r10: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (st == ST_SH_IR || st == ST_SH_DR));

  // R4: the error flag stays set until Test-Logic-Reset
  p_err_sticky_r4: assert property (@(posedge tck) disable iff (!trst_n)
    (err && st != ST_TLR) |=> err);

  // R3: the chain selection only moves in Update-DR or Test-Logic-Reset
  p_chain_hold_r3: assert property (@(posedge tck) disable iff (!trst_n)
    (st != ST_UPD_DR && st != ST_TLR) |=> $stable(chain_q));

endmodule

// File: rtl/jrg_sys_bridge.sv
module jrg_sys_bridge #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              sys_clk,
  input  logic              sys_rst_n,
  input  logic              req_tgl,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic              h_wr,
  input  logic [DATA_W-1:0] h_wdata,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_wr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              ack_tgl,
  output logic [DATA_W-1:0] rdata_q
);

  logic [SYNC_STAGES-1:0] req_sync;
  logic                   req_seen;
  logic                   req_new;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge sys_clk or negedge sys_rst_n)
        if (!sys_rst_n) req_sync <= '0;
        else            req_sync <= req_tgl;
    end else begin : g_syncn
      always_ff @(posedge sys_clk or negedge sys_rst_n)
        if (!sys_rst_n) req_sync <= '0;
        else            req_sync <= {req_sync[SYNC_STAGES-2:0], req_tgl};
    end
  endgenerate

  assign req_new = req_sync[SYNC_STAGES-1] != req_seen;

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      req_seen  <= 1'b0;
      bus_valid <= 1'b0;
      bus_addr  <= '0;
      bus_wr    <= 1'b0;
      bus_wdata <= '0;
      ack_tgl   <= 1'b0;
      rdata_q   <= '0;
    end else if (bus_valid && bus_ready) begin
      bus_valid <= 1'b0;
      ack_tgl   <= ~ack_tgl;
      if (!bus_wr) rdata_q <= bus_rdata;
    end else if (req_new && !bus_valid) begin
      req_seen  <= req_sync[SYNC_STAGES-1];
      bus_valid <= 1'b1;
      bus_addr  <= h_addr;
      bus_wr    <= h_wr;
      bus_wdata <= h_wdata;
    end
  end

  // R9: a stalled request holds its fields
  p_req_hold_r9: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_wr) && $stable(bus_wdata)));

  // R9: valid drops right after the handshake
  p_drop_after_hs_r9: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (bus_valid && bus_ready) |=> !bus_valid);

endmodule

// File: rtl/jtag_regacc_top.sv
module jtag_regacc_top
  import jrg_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int CHAIN_W     = 4,
  parameter int REG_CHAIN   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdo_oe,
  output logic              crc_err,
  input  logic              sys_clk,
  input  logic              sys_rst_n,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_wr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata
);

  tap_st_e st;
  logic              launch, f_wr, busy;
  logic [ADDR_W-1:0] f_addr, h_addr;
  logic [DATA_W-1:0] f_wdata, h_wdata, rd_latch, sys_rdata;
  logic              h_wr, req_tgl, ack_tgl, ack_seen;
  logic [SYNC_STAGES-1:0] ack_sync;

  jrg_tap u_tap (
    .tck(tck), .trst_n(trst_n), .tms(tms), .st(st)
  );

  jrg_scan #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAIN_W(CHAIN_W), .REG_CHAIN(REG_CHAIN)
  ) u_scan (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .st(st), .rd_latch(rd_latch),
    .tdo(tdo), .tdo_oe(tdo_oe), .err(crc_err), .launch(launch),
    .f_addr(f_addr), .f_wr(f_wr), .f_wdata(f_wdata)
  );

  jrg_sys_bridge #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_bridge (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .req_tgl(req_tgl),
    .h_addr(h_addr), .h_wr(h_wr), .h_wdata(h_wdata),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ack_tgl(ack_tgl), .rdata_q(sys_rdata)
  );

  assign busy = req_tgl != ack_seen;

  generate
    if (SYNC_STAGES == 1) begin : g_ack1
      always_ff @(posedge tck or negedge trst_n)
        if (!trst_n) ack_sync <= '0;
        else         ack_sync <= ack_tgl;
    end else begin : g_ackn
      always_ff @(posedge tck or negedge trst_n)
        if (!trst_n) ack_sync <= '0;
        else         ack_sync <= {ack_sync[SYNC_STAGES-2:0], ack_tgl};
    end
  endgenerate

  // TCK-side request launch and completion capture
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      req_tgl  <= 1'b0;
      ack_seen <= 1'b0;
      h_addr   <= '0;
      h_wr     <= 1'b0;
      h_wdata  <= '0;
      rd_latch <= '0;
    end else begin
      if (ack_sync[SYNC_STAGES-1] != ack_seen) begin
        ack_seen <= ack_sync[SYNC_STAGES-1];
        if (!h_wr) rd_latch <= sys_rdata;
      end
      if (launch && !busy) begin
        req_tgl <= ~req_tgl;
        h_addr  <= f_addr;
        h_wr    <= f_wr;
        h_wdata <= f_wdata;
      end
    end
  end

  // R11: a launch during an outstanding access leaves the held request untouched
  p_drop_busy_r11: assert property (@(posedge tck) disable iff (!trst_n)
    (launch && busy) |=> ($stable(h_addr) && $stable(h_wdata) && $stable(h_wr)));

endmodule

// File: tb/tb_jtag_regacc_top.sv
module tb_jtag_regacc_top;

  logic        tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic        sys_clk = 1'b0, sys_rst_n = 1'b0, ready_en = 1'b1;
  logic        tdo, tdo_oe, crc_err, bus_valid, bus_wr;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [31:0] regs [16];

  typedef struct packed { logic wr; logic [31:0] addr; logic [31:0] data; } acc_t;
  acc_t exp_q [$];
  int n_chk = 0, n_fail = 0, n_acc = 0, edge_bad = 0;
  bit done = 0;

  always #5 sys_clk = ~sys_clk;

  jtag_regacc_top dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .crc_err(crc_err), .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
    .bus_valid(bus_valid), .bus_ready(ready_en), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  assign bus_rdata = regs[bus_addr[3:0]];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: bus model and scoreboard
  always @(posedge sys_clk) begin
    if (bus_valid && ready_en) begin
      n_acc++;
      if (bus_wr) regs[bus_addr[3:0]] <= bus_wdata;
      if (exp_q.size() == 0) begin
        chk(0, "R6 unexpected access", {31'd0, bus_wr, bus_addr}, 64'd0);
      end else begin
        acc_t e;
        e = exp_q.pop_front();
        chk(bus_wr == e.wr && bus_addr == e.addr, "R5 access kind/address",
            {31'd0, bus_wr, bus_addr}, {31'd0, e.wr, e.addr});
        if (e.wr) chk(bus_wdata == e.data, "R5 write data", {32'd0, bus_wdata}, {32'd0, e.data});
      end
    end
  end

  task automatic clk(input logic m, input logic d, output logic o);
    tms = m; tdi = d;
    #10 o = tdo;
    tck = 1'b1;
    #5 if (tdo !== o) edge_bad++;
    #15 tck = 1'b0;
    #10;
  endtask

  task automatic idle(input int n);
    logic o;
    repeat (n) clk(1'b0, 1'b0, o);
  endtask

  task automatic tlr_reset();
    logic o;
    repeat (5) clk(1'b1, 1'b0, o);
    clk(1'b0, 1'b0, o);
  endtask

  task automatic scan_ir(input logic [3:0] code, output logic [3:0] out);
    logic o;
    clk(1, 0, o); clk(1, 0, o); clk(0, 0, o); clk(0, 0, o);
    for (int i = 0; i < 4; i++) begin
      clk(i == 3, code[i], o);
      out[i] = o;
    end
    clk(1, 0, o); clk(0, 0, o);
  endtask

  task automatic scan_dr(input logic [127:0] bits, input int n, output logic [127:0] out);
    logic o;
    out = '0;
    clk(1, 0, o); clk(0, 0, o); clk(0, 0, o);
    for (int i = 0; i < n; i++) begin
      clk(i == n - 1, bits[i], o);
      out[i] = o;
    end
    clk(1, 0, o); clk(0, 0, o);
    idle(10);
  endtask

  function automatic logic [7:0] crc_of(input logic [127:0] bits, input int n);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < n; i++) begin
      logic fb;
      fb = c[7] ^ bits[i];
      c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  function automatic logic [127:0] acc_frame(input logic [31:0] a, input logic w, input logic [31:0] d, input bit bad);
    logic [127:0] f = '0;
    f[31:0] = a; f[32] = w; f[64:33] = d;
    f[72:65] = crc_of(f, 65) ^ (bad ? 8'h01 : 8'h00);
    return f;
  endfunction

  function automatic logic [127:0] chain_frame(input logic [3:0] id, input bit bad);
    logic [127:0] f = '0;
    f[3:0] = id;
    f[11:4] = crc_of(f, 4) ^ (bad ? 8'h80 : 8'h00);
    return f;
  endfunction

  task automatic select_chain(input logic [3:0] id, input bit bad);
    logic [3:0] ir_o;
    logic [127:0] o;
    scan_ir(4'h3, ir_o);
    scan_dr(chain_frame(id, bad), 12, o);
  endtask

  task automatic access(input logic [31:0] a, input logic w, input logic [31:0] d,
                        input bit bad, input int len, input bit expect_it, output logic [31:0] rd);
    logic [3:0] ir_o;
    logic [127:0] o;
    if (expect_it) exp_q.push_back('{wr: w, addr: a, data: d});
    scan_ir(4'h8, ir_o);
    scan_dr(acc_frame(a, w, d, bad), len, o);
    rd = o[64:33];
    chk(o[32:0] == 33'd0 && o[72:65] == 8'd0, "R7 non-data bits zero", {31'd0, o[32:0]}, 64'd0);
  endtask

  initial begin
    logic [3:0]   ir_o;
    logic [127:0] o;
    logic [31:0]  rd;
    int a0;
    for (int i = 0; i < 16; i++) regs[i] = 32'hA500_0000 | i;
    #100 trst_n = 1'b1; sys_rst_n = 1'b1;
    #20;
    chk(tdo_oe == 1'b0 && crc_err == 1'b0 && bus_valid == 1'b0, "R1 reset state",
        {61'd0, tdo_oe, crc_err, bus_valid}, 64'd0);
    idle(1);
    chk(tdo_oe == 1'b0, "R10 no enable in idle", {63'd0, tdo_oe}, 64'd0);

    // IR capture pattern and bypass delay
    scan_ir(4'hF, ir_o);
    chk(ir_o == 4'b0101, "R2 IR capture", {60'd0, ir_o}, 64'h5);
    scan_dr(128'hB2, 8, o);
    chk(o[7:0] == 8'h64, "R2 bypass delay", {56'd0, o[7:0]}, 64'h64);

    // access before chain 4 selected, and with chain 2 selected
    a0 = n_acc;
    access(32'd5, 1'b1, 32'hDEAD_0001, 0, 73, 0, rd);
    chk(n_acc == a0 && crc_err == 1'b0, "R6 no chain selected", {32'(n_acc), 31'd0, crc_err}, {32'(a0), 32'd0});
    select_chain(4'h2, 0);
    access(32'd5, 1'b1, 32'hDEAD_0002, 0, 73, 0, rd);
    chk(n_acc == a0 && crc_err == 1'b0, "R6 wrong chain", {32'(n_acc), 31'd0, crc_err}, {32'(a0), 32'd0});

    // bad CRC on chain select: error, selection kept
    select_chain(4'h4, 1);
    chk(crc_err == 1'b1, "R4 chain CRC error", {63'd0, crc_err}, 64'd1);
    access(32'd5, 1'b1, 32'hDEAD_0003, 0, 73, 0, rd);
    chk(n_acc == a0, "R3 selection kept after bad CRC", 64'(n_acc), 64'(a0));
    tlr_reset();
    chk(crc_err == 1'b0, "R1 TMS reset clears error", {63'd0, crc_err}, 64'd0);

    // select chain 4 and write
    select_chain(4'h4, 0);
    chk(crc_err == 1'b0, "R3 good chain select", {63'd0, crc_err}, 64'd0);
    access(32'd5, 1'b1, 32'h1234_5678, 0, 73, 1, rd);
    chk(regs[5] == 32'h1234_5678 && n_acc == a0 + 1, "R8 write done within window",
        {32'd0, regs[5]}, 64'h1234_5678);

    // reads: value of one read appears on the next scan
    access(32'd5, 1'b0, 32'd0, 0, 73, 1, rd);
    chk(rd == 32'd0, "R7 first read after reset", {32'd0, rd}, 64'd0);
    access(32'd5, 1'b0, 32'd0, 0, 73, 1, rd);
    chk(rd == 32'h1234_5678, "R7 repeated read", {32'd0, rd}, 64'h1234_5678);
    access(32'd2, 1'b0, 32'd0, 0, 73, 1, rd);
    chk(rd == 32'h1234_5678, "R7 previous value shifted", {32'd0, rd}, 64'h1234_5678);
    access(32'd2, 1'b0, 32'd0, 0, 73, 1, rd);
    chk(rd == 32'hA500_0002, "R7 second register", {32'd0, rd}, 64'hA500_0002);

    // corrupted CRC and wrong length on the register chain
    a0 = n_acc;
    access(32'd3, 1'b1, 32'hBAD0_0000, 1, 73, 0, rd);
    chk(crc_err == 1'b1 && n_acc == a0 && regs[3] == 32'hA500_0003, "R4 access CRC error",
        {31'd0, crc_err, regs[3]}, {31'd1, 32'hA500_0003});
    tlr_reset();
    select_chain(4'h4, 0);
    access(32'd3, 1'b1, 32'hBAD0_0001, 0, 72, 0, rd);
    chk(crc_err == 1'b1 && n_acc == a0, "R12 short frame rejected", {31'd0, crc_err, 32'(n_acc)}, {31'd1, 32'(a0)});
    tlr_reset();
    select_chain(4'h4, 0);

    // stalled bus: request held, second frame dropped
    ready_en = 1'b0;
    access(32'd6, 1'b1, 32'h6666_0006, 0, 73, 1, rd);
    chk(bus_valid == 1'b1 && bus_addr == 32'd6 && bus_wdata == 32'h6666_0006, "R9 request held while stalled",
        {31'd0, bus_valid, bus_addr}, {31'd1, 32'd6});
    access(32'd7, 1'b1, 32'h7777_0007, 0, 73, 0, rd);
    chk(bus_addr == 32'd6 && bus_wdata == 32'h6666_0006, "R9 fields stable", {32'd0, bus_wdata}, 64'h6666_0006);
    ready_en = 1'b1;
    idle(20);
    chk(regs[6] == 32'h6666_0006 && regs[7] == 32'hA500_0007 && n_acc == a0 + 1 && bus_valid == 1'b0,
        "R11 busy frame dropped", {32'(n_acc), regs[7]}, {32'(a0 + 1), 32'hA500_0007});
    chk(exp_q.size() == 0, "R5 all expected accesses seen", 64'(exp_q.size()), 64'd0);
    chk(edge_bad == 0, "R10 TDO stable at rising edge", 64'(edge_bad), 64'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_900_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule